// File: doc/BRIEF.md
# Vectored Interrupt Mask Controller

This block sits next to the instruction sequencer of a small 8-bit processor. It decides whether a maskable interrupt may be taken, and if one may, which one. A single global enable bit is set by an enable-interrupts command and cleared by a disable-interrupts command. Three vectored inputs (called 5.5, 6.5 and 7.5 here, in rising priority) can each be masked on their own. Inputs 5.5 and 6.5 are sampled as levels. Input 7.5 is caught by a rising-edge latch.

The core writes the masks through a set-mask strobe and reads the whole state back as one 7-bit word. When an unmasked source is pending and interrupts are open, the block raises a request together with a restart address. The core answers with a one-cycle acknowledge.

Top module: `intr_mask_ctrl`

## Requirements
- R1: After a synchronous active-low reset: global enable is 0, the enable hold is clear, all three mask bits are 1 (masked), the 7.5 latch is empty and `int_req` is 0.
- R2: A pulse on `ei_cmd` sets the global enable and a pulse on `di_cmd` clears it. When both pulse in the same cycle, `di_cmd` wins.
- R3: After `ei_cmd`, `int_req` stays 0 until one `instr_done` pulse has been registered. The request may assert from the cycle after that pulse.
- R4: A `msk_wr` pulse loads `msk_wdata[2:0]` into the masks only when `msk_wdata[3]` is 1. Bit 0 masks 5.5, bit 1 masks 6.5, bit 2 masks 7.5, and 1 means masked. If `msk_wdata[3]` is 0, the masks keep their value.
- R5: A `msk_wr` pulse with `msk_wdata[4]` = 1 empties the 7.5 latch, whatever the value of `msk_wdata[3]`.
- R6: The pending bits of 5.5 and 6.5 follow the `irq_lo` and `irq_mid` levels directly, with no storage.
- R7: A 0-to-1 change of `irq_hi` between two clock edges sets the 7.5 latch. The latch stays set after `irq_hi` falls, and it captures even while 7.5 is masked.
- R8: Among the unmasked pending sources, 7.5 wins over 6.5, and 6.5 wins over 5.5. `int_vec` is 8'h3C for 7.5, 8'h34 for 6.5 and 8'h2C for 5.5.
- R9: `int_req` is 1 exactly when the global enable is 1, the hold is clear, and at least one pending source is unmasked.
- R10: `int_ack` while `int_req` is 1 clears the global enable, and empties the 7.5 latch only when 7.5 was the source served. `int_ack` while `int_req` is 0 has no effect.
- R11: If a clear of the 7.5 latch and a new rising edge on `irq_hi` fall in the same cycle, the latch ends up set.
- R12: `rd_state` is {pending 7.5, pending 6.5, pending 5.5, global enable, mask 7.5, mask 6.5, mask 5.5}, from bit 6 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ei_cmd | input | 1 | Enable-interrupts command pulse |
| di_cmd | input | 1 | Disable-interrupts command pulse |
| instr_done | input | 1 | Pulse when an instruction completes |
| msk_wr | input | 1 | Set-mask write strobe |
| msk_wdata | input | 5 | Masks [2:0], mask-load enable [3], clear 7.5 latch [4] |
| irq_lo | input | 1 | Level input 5.5 |
| irq_mid | input | 1 | Level input 6.5 |
| irq_hi | input | 1 | Edge input 7.5 |
| int_ack | input | 1 | Acknowledge from the core |
| int_req | output | 1 | Interrupt request to the core |
| int_vec | output | 8 | Restart address of the selected source |
| rd_state | output | 7 | Read-back word (layout in R12) |

## Verification
Two events can hit the 7.5 latch in the same cycle: a clear and a fresh rising edge. The clear can come from a set-mask write with the clear bit, or from an acknowledge that serves 7.5. The bench provokes the write-driven collision by raising `irq_hi` in the very cycle that carries the clearing write. It then reads the word back and expects the latch to be set.

The bench also collides an enable with a disable in one cycle and expects the enable to be off afterwards. A sweep over every mask value and every pending pattern checks the request, the vector and the read word against a priority model in the bench.

// File: rtl/imc_pkg.sv
// Package: shared constants and the read-back word layout for the
// interrupt mask controller. Assumes three sources, indexed 0..2 in
// rising priority.
package imc_pkg;
    localparam int NSRC       = 3;
    localparam int VW         = 8;
    localparam int WR_W       = 5;
    localparam int WR_LOAD    = 3;   // write bit that allows the mask load
    localparam int WR_CLR_HI  = 4;   // write bit that empties the edge latch
    localparam logic [VW-1:0] VEC_BASE = 8'h2C;
    localparam logic [VW-1:0] VEC_STEP = 8'h08;
    localparam int RD_W       = 2*NSRC + 1;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            gie;
        logic [NSRC-1:0] mask;
    } imc_rd_t;
endpackage

// File: rtl/imc_enable.sv
// Global enable and post-enable hold. The hold keeps requests off until
// one instruction has completed after an enable command. Priority of the
// updates: disable, then enable, then acceptance/completion.
module imc_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic ei,
    input  logic di,
    input  logic done,
    input  logic take,
    output logic gie,
    output logic hold
);
    // Update the enable and the hold once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie  <= 1'b0;
            hold <= 1'b0;
        end else if (di) begin
            gie  <= 1'b0;
            hold <= 1'b0;
        end else if (ei) begin
            gie  <= 1'b1;
            hold <= 1'b1;
        end else begin
            if (take) gie  <= 1'b0;
            if (done) hold <= 1'b0;
        end
    end

    AST_DI_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) di |=> !gie);               // R2
    AST_EI_SETS:    assert property (@(posedge clk) disable iff (!rst_n) (ei && !di) |=> (gie && hold)); // R2
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (take && !ei && !di) |=> !gie); // R10
endmodule

// File: rtl/imc_edge_latch.sv
// Rising-edge capture latch. Assumes din is already synchronous to clk.
// A new edge in the same cycle as a clear leaves the latch set.
module imc_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic rise;

    assign rise = din & ~prev_q;

    // Remember the last sampled input level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    // Set on an edge, otherwise hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= rise | (pend & ~clr);
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n) rise |=> pend);                 // R11
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (clr && !rise) |=> !pend);    // R5
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (pend && !clr) |=> pend);     // R7
endmodule

// File: rtl/imc_prio.sv
// Fixed-priority selector: the highest index wins. Produces a one-hot
// grant and the restart address base + step * index.
module imc_prio #(
    parameter int N = imc_pkg::NSRC,
    parameter int VW = imc_pkg::VW,
    parameter logic [VW-1:0] VBASE = imc_pkg::VEC_BASE,
    parameter logic [VW-1:0] VSTEP = imc_pkg::VEC_STEP
) (
    input  logic [N-1:0]  eff,
    output logic          any,
    output logic [N-1:0]  grant,
    output logic [VW-1:0] vec
);
    // Scan upward so that a higher index overrides a lower one.
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = 0; i < N; i++) begin
            if (eff[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = VW'(VBASE + VSTEP * VW'(i));
            end
        end
    end

    assign any = |eff;

    AST_GRANT_ONEHOT: assert final ($onehot0(grant));          // R8
    AST_GRANT_IN_EFF: assert final ((grant & ~eff) == '0);     // R8
endmodule

// File: rtl/intr_mask_ctrl.sv
// Top: interrupt mask controller. Holds the mask register, merges the
// level and edge sources, and raises a request with a restart address.
// Assumes all inputs are synchronous to clk and the commands are pulses.
module intr_mask_ctrl
    import imc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ei_cmd,
    input  logic              di_cmd,
    input  logic              instr_done,
    input  logic              msk_wr,
    input  logic [WR_W-1:0]   msk_wdata,
    input  logic              irq_lo,
    input  logic              irq_mid,
    input  logic              irq_hi,
    input  logic              int_ack,
    output logic              int_req,
    output logic [VW-1:0]     int_vec,
    output logic [RD_W-1:0]   rd_state
);
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] eff;
    logic [NSRC-1:0] grant;
    logic            any;
    logic            gie;
    logic            hold;
    logic            take;
    logic            hi_pend;
    logic            hi_clr;
    logic            mask_load;
    imc_rd_t         rd;

    assign mask_load = msk_wr & msk_wdata[WR_LOAD];

    // Mask register: loads only when the write carries the load bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_load) mask_q <= msk_wdata[NSRC-1:0];
    end

    imc_edge_latch u_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_hi),
        .clr  (hi_clr),
        .pend (hi_pend)
    );

    assign pend = {hi_pend, irq_mid, irq_lo};
    assign eff  = pend & ~mask_q;

    imc_prio #(.N(NSRC), .VW(VW), .VBASE(VEC_BASE), .VSTEP(VEC_STEP)) u_prio (
        .eff  (eff),
        .any  (any),
        .grant(grant),
        .vec  (int_vec)
    );

    imc_enable u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .ei   (ei_cmd),
        .di   (di_cmd),
        .done (instr_done),
        .take (take),
        .gie  (gie),
        .hold (hold)
    );

    assign int_req = gie & ~hold & any;
    assign take    = int_ack & int_req;
    assign hi_clr  = (msk_wr & msk_wdata[WR_CLR_HI]) | (take & grant[NSRC-1]);

    assign rd.pend  = pend;
    assign rd.gie   = gie;
    assign rd.mask  = mask_q;
    assign rd_state = rd;

    AST_REQ_NEEDS_GIE:  assert property (@(posedge clk) disable iff (!rst_n) int_req |-> (gie && !hold));          // R9
    AST_REQ_UNMASKED:   assert property (@(posedge clk) disable iff (!rst_n) int_req |-> ((pend & ~mask_q) != '0)); // R9
    AST_MASK_NOLOAD:    assert property (@(posedge clk) disable iff (!rst_n) !mask_load |=> $stable(mask_q));       // R4
    AST_EI_HOLD:        assert property (@(posedge clk) disable iff (!rst_n) (ei_cmd && !di_cmd) |=> !int_req);     // R3
endmodule

// File: tb/sim_intr_mask_ctrl.sv
module sim_intr_mask_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ei_cmd = 0, di_cmd = 0, instr_done = 0, msk_wr = 0;
    logic [4:0] msk_wdata = '0;
    logic       irq_lo = 0, irq_mid = 0, irq_hi = 0, int_ack = 0;
    logic       int_req;
    logic [7:0] int_vec;
    logic [6:0] rd_state;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    intr_mask_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .instr_done(instr_done), .msk_wr(msk_wr), .msk_wdata(msk_wdata),
        .irq_lo(irq_lo), .irq_mid(irq_mid), .irq_hi(irq_hi), .int_ack(int_ack),
        .int_req(int_req), .int_vec(int_vec), .rd_state(rd_state)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_vec(input logic [2:0] e);
        if (e[2])      return 8'h3C;
        else if (e[1]) return 8'h34;
        else           return 8'h2C;
    endfunction

    task automatic wr(input logic [4:0] d);
        msk_wr = 1; msk_wdata = d; tick(); msk_wr = 0; msk_wdata = '0;
    endtask

    task automatic enable_open();
        ei_cmd = 1; tick(); ei_cmd = 0;
        instr_done = 1; tick(); instr_done = 0;
    endtask

    task automatic fire_hi();
        irq_hi = 1; tick(); irq_hi = 0; tick();
    endtask

    initial begin
        #200_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1: reset state
        chk("R1 rd_state", rd_state, 7'b000_0_111);
        chk("R1 int_req", int_req, 0);
        rst_n = 1; tick();

        // R2: enable, then a simultaneous enable+disable
        ei_cmd = 1; tick(); ei_cmd = 0;
        chk("R2 gie set", rd_state[3], 1);
        ei_cmd = 1; di_cmd = 1; tick(); ei_cmd = 0; di_cmd = 0;
        chk("R2 di wins", rd_state[3], 0);

        // R4: a write without the load bit leaves the masks alone
        wr(5'b0_0_000);
        chk("R4 no load", rd_state[2:0], 3'b111);
        wr(5'b0_1_010);
        chk("R4 load", rd_state[2:0], 3'b010);

        // Sweep: every mask against every pending pattern (R3 R6 R8 R9 R12)
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                logic [2:0] e;
                di_cmd = 1; tick(); di_cmd = 0;
                wr({1'b1, 1'b1, 3'(m)});
                if (p[2]) fire_hi();
                irq_lo = p[0]; irq_mid = p[1];
                #1;
                e = 3'(p) & ~3'(m);
                chk("R9 closed", int_req, 0);
                ei_cmd = 1; tick(); ei_cmd = 0;
                chk("R3 hold", int_req, 0);
                instr_done = 1; tick(); instr_done = 0;
                chk("R9 req", int_req, int'(|e));
                if (|e) chk("R8 vec", int_vec, exp_vec(e));
                chk("R12 word", rd_state, {3'(p), 1'b1, 3'(m)});
                irq_lo = 0; irq_mid = 0; #1;
                chk("R6 level drop", rd_state[5:4], 0);
            end
        end

        // R7: latch captures while masked and survives the input fall
        di_cmd = 1; tick(); di_cmd = 0;
        wr(5'b1_1_100);
        fire_hi();
        chk("R7 masked capture", rd_state[6], 1);

        // R5: clear bit without the load bit empties the latch
        wr(5'b1_0_000);
        chk("R5 clear", rd_state[6], 0);
        chk("R5 masks kept", rd_state[2:0], 3'b100);

        // R11: clear and new edge in the same cycle
        msk_wr = 1; msk_wdata = 5'b1_0_000; irq_hi = 1; tick();
        msk_wr = 0; msk_wdata = '0; irq_hi = 0; tick();
        chk("R11 edge wins", rd_state[6], 1);

        // R10: ack of 7.5 clears enable and latch
        wr(5'b0_1_000);
        irq_lo = 1;
        enable_open();
        chk("R10 vec hi", int_vec, 8'h3C);
        int_ack = 1; tick(); int_ack = 0;
        chk("R10 gie off", rd_state[3], 0);
        chk("R10 latch served", rd_state[6], 0);
        // ack of 6.5 with 7.5 masked leaves the latch
        irq_lo = 0; irq_mid = 1;
        wr(5'b0_1_100);
        fire_hi();
        enable_open();
        chk("R10 vec mid", int_vec, 8'h34);
        int_ack = 1; tick(); int_ack = 0;
        chk("R10 latch kept", rd_state[6], 1);
        chk("R10 gie off 2", rd_state[3], 0);
        // ack without request is ignored
        irq_mid = 0;
        wr(5'b1_1_111);
        enable_open();
        chk("R10 no req", int_req, 0);
        int_ack = 1; tick(); int_ack = 0;
        chk("R10 ignored ack", rd_state[3], 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule